// File: doc/BRIEF.md
# SDRAM Self-Refresh Exit and Refresh Scheduler

This block brings an SDRAM device out of self-refresh and then keeps its rows refreshed. While the device sits in self-refresh, the block holds the clock-enable pin low. When the system asks for an exit, the block waits until the system also reports that the memory clock is running within its limits. Only then does it raise clock enable. After that it places nothing but no-operation commands on the command pins for a guard period. The guard period is the longer of a fixed minimum number of clocks and the exit-to-first-command delay.

Once the guard period has ended, the block raises `ready`. From that point the rest of the controller may use the device. Because self-refresh and auto-refresh share one internal row counter, the block starts a fresh refresh interval at that same moment. When the interval runs out, it asks the main arbiter for a refresh slot. When the slot is granted, it drives a single AUTO REFRESH command.

All timing limits are parameters given in nanoseconds. They are turned into clock counts at elaboration, and minimum delays are rounded up to whole clocks. The refresh interval is a maximum, so it is rounded down instead.

Top module: `srx_sdram_exit`

## Requirements
- R1: While `rst` is high at a clock edge, and on the first cycle after it, `cke`, `ready` and `ref_req` are 0 and the command pins carry NOP. NOP is `cs_n`=0, `ras_n`=1, `cas_n`=1, `we_n`=1.
- R2: `cke` stays 0 until a clock edge at which an exit has been requested and `clk_stable` is 1. A one-cycle `exit_req` seen while `clk_stable` is 0 is remembered. `cke` goes to 1 in the cycle after the edge that sees `clk_stable` high.
- R3: While `cke` is 1 and `ready` is 0, the command pins carry only NOP.
- R4: `ready` rises exactly NOP_CYC clock edges after `cke` rises. NOP_CYC = max(MIN_NOP_CLK, ceil(TXSR_NS/TCK_NS)), and MIN_NOP_CLK defaults to 2.
- R5: Once `ready` is 1, it stays 1 and `cke` stays 1 until reset, whatever `exit_req` and `clk_stable` do.
- R6: `ref_req` rises exactly REFI_CYC clock edges after `ready` rises, with REFI_CYC = floor(TREFI_NS/TCK_NS).
- R7: `ref_req` stays 1 until `ref_ack` is sampled high. At that edge `ref_req` falls, and the command pins carry AUTO REFRESH for one cycle. AUTO REFRESH is `cs_n`=0, `ras_n`=0, `cas_n`=0, `we_n`=1. The next `ref_req` rises REFI_CYC edges after that acknowledge.
- R8: A `ref_ack` sampled while `ref_req` is 0 produces no AUTO REFRESH and does not move the next request.
- R9: A `ref_ack` during the exit sequence (`ready` low) produces no AUTO REFRESH and does not change when `ready` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock, period TCK_NS |
| rst | input | 1 | Synchronous active-high reset to the self-refresh state |
| exit_req | input | 1 | Request to leave self-refresh (a pulse is enough) |
| clk_stable | input | 1 | Memory clock is within its limits |
| ref_ack | input | 1 | Arbiter grants the pending refresh slot |
| cke | output | 1 | Clock enable to the SDRAM |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ready | output | 1 | Exit finished; other traffic may proceed |
| ref_req | output | 1 | Refresh slot wanted |

## Verification
The hardest situation to reach is the boundary of the periodic schedule. Here a stray acknowledge lands in the middle of an interval, and the next request must still arrive exactly REFI_CYC edges after the last real grant. The stimulus gets there by first walking the block through a full exit. It then holds a request pending for a while, grants it, and injects a lone acknowledge a hundred cycles into the following interval while counting edges to the next request. The remembered-exit case is reached in a similar way: a one-cycle exit request is given while the clock-stable flag is low, and only later is the flag raised.

// File: rtl/srx_pkg.sv
`timescale 1ns/1ps
package srx_pkg;

  typedef enum logic [1:0] {
    ST_SELF     = 2'd0,
    ST_WAIT_CLK = 2'd1,
    ST_EXIT_NOP = 2'd2,
    ST_RUN      = 2'd3
  } srx_state_e;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sdr_cmd_t;

  localparam sdr_cmd_t CMD_NOP = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
  localparam sdr_cmd_t CMD_REF = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};

  // minimum delays: round up to a whole clock
  function automatic int unsigned ns_to_clk_up(input int unsigned ns, input int unsigned tck);
    return (ns + tck - 1) / tck;
  endfunction

  // maximum intervals: round down so the limit is never exceeded
  function automatic int unsigned ns_to_clk_down(input int unsigned ns, input int unsigned tck);
    return ns / tck;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/srx_exit_seq.sv
`timescale 1ns/1ps
module srx_exit_seq
  import srx_pkg::*;
#(
  parameter int unsigned NOP_CYC = 2,
  localparam int unsigned CNT_W  = (NOP_CYC < 2) ? 1 : $clog2(NOP_CYC)
) (
  input  logic clk,
  input  logic rst,
  input  logic exit_req,
  input  logic clk_stable,
  output logic cke_o,
  output logic run_o,
  output logic run_start_o
);

  localparam logic [CNT_W-1:0] NOP_LOAD = CNT_W'(NOP_CYC - 1);

  srx_state_e        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cke_q, run_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_SELF: begin
        if (exit_req) begin
          if (clk_stable) begin
            state_d = ST_EXIT_NOP;
            cnt_d   = NOP_LOAD;
          end else begin
            state_d = ST_WAIT_CLK;
          end
        end
      end
      ST_WAIT_CLK: begin
        if (clk_stable) begin
          state_d = ST_EXIT_NOP;
          cnt_d   = NOP_LOAD;
        end
      end
      ST_EXIT_NOP: begin
        if (cnt_q == '0) begin
          state_d = ST_RUN;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_RUN: begin
        state_d = ST_RUN;
      end
      default: state_d = ST_SELF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_SELF;
      cnt_q   <= '0;
      cke_q   <= 1'b0;
      run_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      cke_q   <= (state_d == ST_EXIT_NOP) || (state_d == ST_RUN);
      run_q   <= (state_d == ST_RUN);
    end
  end

  assign cke_o       = cke_q;
  assign run_o       = run_q;
  assign run_start_o = (state_q == ST_EXIT_NOP) && (cnt_q == '0);

endmodule

// File: rtl/srx_refresh_timer.sv
`timescale 1ns/1ps
module srx_refresh_timer #(
  parameter int unsigned REFI_CYC = 1562,
  localparam int unsigned CNT_W   = (REFI_CYC < 2) ? 1 : $clog2(REFI_CYC)
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic run,
  input  logic ack,
  output logic req_o,
  output logic grant_o
);

  localparam logic [CNT_W-1:0] REFI_LOAD = CNT_W'(REFI_CYC - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             req_q;
  logic             grant;

  assign grant = run && req_q && ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      req_q <= 1'b0;
    end else if (start) begin
      cnt_q <= REFI_LOAD;
      req_q <= 1'b0;
    end else if (run) begin
      if (grant) begin
        req_q <= 1'b0;
        cnt_q <= REFI_LOAD;
      end else if (!req_q) begin
        if (cnt_q == '0) begin
          req_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign req_o   = req_q;
  assign grant_o = grant;

endmodule

// File: rtl/srx_cmd_drive.sv
`timescale 1ns/1ps
module srx_cmd_drive
  import srx_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     issue_ref,
  output sdr_cmd_t cmd_o
);

  sdr_cmd_t cmd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= CMD_NOP;
    end else begin
      cmd_q <= issue_ref ? CMD_REF : CMD_NOP;
    end
  end

  assign cmd_o = cmd_q;

endmodule

// File: rtl/srx_sdram_exit.sv
`timescale 1ns/1ps
module srx_sdram_exit
  import srx_pkg::*;
#(
  parameter int unsigned TCK_NS      = 5,
  parameter int unsigned TXSR_NS     = 67,
  parameter int unsigned TREFI_NS    = 7810,
  parameter int unsigned MIN_NOP_CLK = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic exit_req,
  input  logic clk_stable,
  input  logic ref_ack,
  output logic cke,
  output logic cs_n,
  output logic ras_n,
  output logic cas_n,
  output logic we_n,
  output logic ready,
  output logic ref_req
);

  localparam int unsigned NOP_CYC  = max_u(MIN_NOP_CLK, ns_to_clk_up(TXSR_NS, TCK_NS));
  localparam int unsigned REFI_CYC = ns_to_clk_down(TREFI_NS, TCK_NS);

  logic     run, run_start, grant;
  sdr_cmd_t cmd;

  srx_exit_seq #(.NOP_CYC(NOP_CYC)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .exit_req    (exit_req),
    .clk_stable  (clk_stable),
    .cke_o       (cke),
    .run_o       (run),
    .run_start_o (run_start)
  );

  srx_refresh_timer #(.REFI_CYC(REFI_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .start   (run_start),
    .run     (run),
    .ack     (ref_ack),
    .req_o   (ref_req),
    .grant_o (grant)
  );

  srx_cmd_drive u_cmd (
    .clk       (clk),
    .rst       (rst),
    .issue_ref (grant),
    .cmd_o     (cmd)
  );

  assign ready = run;
  assign cs_n  = cmd.cs_n;
  assign ras_n = cmd.ras_n;
  assign cas_n = cmd.cas_n;
  assign we_n  = cmd.we_n;

endmodule

// File: rtl/srx_sdram_exit_chk.sv
`timescale 1ns/1ps
module srx_sdram_exit_chk
  import srx_pkg::*;
#(
  parameter int unsigned TCK_NS      = 5,
  parameter int unsigned TXSR_NS     = 67,
  parameter int unsigned MIN_NOP_CLK = 2
) (
  input logic clk,
  input logic rst,
  input logic exit_req,
  input logic clk_stable,
  input logic ref_ack,
  input logic cke,
  input logic cs_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic ready,
  input logic ref_req
);

  localparam int unsigned NOP_CYC = max_u(MIN_NOP_CLK, ns_to_clk_up(TXSR_NS, TCK_NS));

  logic [15:0] guard_cnt;
  logic        is_nop, is_ref;

  assign is_nop = !cs_n && ras_n && cas_n && we_n;
  assign is_ref = !cs_n && !ras_n && !cas_n && we_n;

  always_ff @(posedge clk) begin
    if (rst || !cke) guard_cnt <= '0;
    else if (!ready && guard_cnt != 16'hFFFF) guard_cnt <= guard_cnt + 1'b1;
  end

  p_cke_after_stable_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> $past(clk_stable));

  p_nop_only_r3: assert property (@(posedge clk) disable iff (rst)
    (cke && !ready) |-> is_nop);

  p_guard_length_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> (guard_cnt == 16'(NOP_CYC)));

  p_ready_sticks_r5: assert property (@(posedge clk) disable iff (rst)
    ready |=> (ready && cke));

  p_req_held_r7: assert property (@(posedge clk) disable iff (rst)
    (ref_req && !ref_ack) |=> ref_req);

  p_grant_issues_r7: assert property (@(posedge clk) disable iff (rst)
    (ref_req && ref_ack) |=> (!ref_req && is_ref));

  p_no_stray_ref_r8: assert property (@(posedge clk) disable iff (rst)
    (!ref_req) |=> !is_ref);

  p_no_ref_in_exit_r9: assert property (@(posedge clk) disable iff (rst)
    (!ready) |-> !is_ref);

endmodule

bind srx_sdram_exit srx_sdram_exit_chk #(
  .TCK_NS      (TCK_NS),
  .TXSR_NS     (TXSR_NS),
  .MIN_NOP_CLK (MIN_NOP_CLK)
) u_srx_chk (.*);

// File: tb/test_srx_sdram_exit.sv
`timescale 1ns/1ps
module test_srx_sdram_exit;

  localparam int TCK_NS = 5, TXSR_NS = 67, TREFI_NS = 7810, MIN_NOP = 2;
  localparam int NOP_EXP  = ((TXSR_NS + TCK_NS - 1) / TCK_NS > MIN_NOP) ?
                            (TXSR_NS + TCK_NS - 1) / TCK_NS : MIN_NOP;
  localparam int REFI_EXP = TREFI_NS / TCK_NS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic exit_req = 1'b0, clk_stable = 1'b0, ref_ack = 1'b0;
  logic cke, cs_n, ras_n, cas_n, we_n, ready, ref_req;

  int checks = 0, failures = 0, cycles = 0;

  always #2.5 clk = ~clk;

  srx_sdram_exit #(.TCK_NS(TCK_NS), .TXSR_NS(TXSR_NS), .TREFI_NS(TREFI_NS),
                   .MIN_NOP_CLK(MIN_NOP)) i_srx_sdram_exit (
    .clk(clk), .rst(rst), .exit_req(exit_req), .clk_stable(clk_stable),
    .ref_ack(ref_ack), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ready(ready), .ref_req(ref_req));

  function automatic logic [3:0] pins();
    return {cs_n, ras_n, cas_n, we_n};
  endfunction

  localparam logic [3:0] NOP = 4'b0111, AREF = 4'b0001;

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic t_reset_r1();
    rst = 1'b1; exit_req = 0; ref_ack = 0; clk_stable = 0;
    repeat (3) @(negedge clk);
    chk({cke, ready, ref_req} == 3'b000, "R1 reset flags", {cke, ready, ref_req}, 0);
    chk(pins() == NOP, "R1 reset pins", pins(), NOP);
    rst = 1'b0;
    @(negedge clk);
    chk({cke, ready, ref_req} == 3'b000, "R1 after release", {cke, ready, ref_req}, 0);
  endtask

  // measures guard period from cke seen high, with a stray ack inside (R3, R4, R9)
  task automatic measure_guard();
    int n = 0;
    int bad = 0;
    while (!ready && n < 200) begin
      if (n == 3) ref_ack = 1'b1;
      if (n == 4) ref_ack = 1'b0;
      @(negedge clk);
      n++;
      if (!ready && pins() != NOP) bad++;
      if (pins() == AREF) bad++;
    end
    ref_ack = 1'b0;
    chk(bad == 0, "R3 only NOP during guard", bad, 0);
    chk(bad == 0, "R9 ack ignored during exit", bad, 0);
    chk(n == NOP_EXP, "R4 guard length", n, NOP_EXP);
  endtask

  task automatic t_exit_wait_clock_r2();
    clk_stable = 0;
    @(negedge clk); exit_req = 1;
    @(negedge clk); exit_req = 0;
    repeat (5) @(negedge clk);
    chk(cke == 1'b0, "R2 cke low without stable clock", cke, 0);
    clk_stable = 1;
    @(negedge clk);
    chk(cke == 1'b1, "R2 cke rises after stable clock", cke, 1);
    measure_guard();
  endtask

  task automatic t_exit_direct_r2();
    clk_stable = 1;
    chk(cke == 1'b0, "R2 cke low before request", cke, 0);
    exit_req = 1;
    @(negedge clk); exit_req = 0;
    chk(cke == 1'b1, "R2 cke after request", cke, 1);
    measure_guard();
  endtask

  task automatic t_first_refresh_r6();
    int n = 0;
    int drop = 0;
    while (!ref_req && n < 5000) begin
      if (n == 50) begin exit_req = 1; clk_stable = 0; end
      if (n == 51) begin exit_req = 0; clk_stable = 1; end
      @(negedge clk);
      n++;
      if (!ready || !cke) drop++;
    end
    chk(drop == 0, "R5 ready and cke stay high", drop, 0);
    chk(n == REFI_EXP, "R6 first request interval", n, REFI_EXP);
  endtask

  task automatic t_hold_and_grant_r7();
    int held = 0;
    repeat (20) begin
      @(negedge clk);
      if (ref_req && pins() == NOP) held++;
    end
    chk(held == 20, "R7 request held without ack", held, 20);
    ref_ack = 1;
    @(negedge clk);
    ref_ack = 0;
    chk(pins() == AREF, "R7 AUTO REFRESH on grant", pins(), AREF);
    chk(ref_req == 1'b0, "R7 request drops on grant", ref_req, 0);
    @(negedge clk);
    chk(pins() == NOP, "R7 single refresh cycle", pins(), NOP);
  endtask

  task automatic t_next_interval_r8();
    int n = 1;
    int stray = 0;
    while (!ref_req && n < 5000) begin
      if (n == 100) ref_ack = 1;
      if (n == 101) ref_ack = 0;
      @(negedge clk);
      n++;
      if (pins() == AREF) stray++;
    end
    ref_ack = 0;
    chk(stray == 0, "R8 stray ack gives no refresh", stray, 0);
    chk(n == REFI_EXP, "R8 interval after grant unchanged", n, REFI_EXP);
  endtask

  initial begin
    t_reset_r1();
    t_exit_wait_clock_r2();
    t_first_refresh_r6();
    t_hold_and_grant_r7();
    t_next_interval_r8();
    t_reset_r1();
    t_exit_direct_r2();
    t_first_refresh_r6();
    finish_run();
  end

endmodule